// File: doc/BRIEF.md
# RV64I Integer Execute Unit

This block is the combinational execute stage of a 64-bit integer core. Each cycle it receives the decoded instruction fields that matter for arithmetic: the 7-bit major opcode, funct3, funct7 and instruction bit 30. It also receives both source register values, the already sign-extended immediate and the program counter. From these it forms the 64-bit value to be written to the destination register.

It covers the register-immediate and register-register arithmetic, logic, shift and compare groups. It also covers their 32-bit word counterparts and the two upper-immediate forms. One adder, one shifter and one comparator serve every group. A word operation differs from a full-width one in two ways: its shift amount is narrowed to five bits, and its 32-bit result is sign-extended afterwards.

Any encoding outside the supported set raises an illegal-instruction flag, and the result is forced to zero. The block has no clock and holds no state, so outputs follow inputs within one cycle of the surrounding pipeline.

Top module: `int_exec_unit`

## Requirements
- R1: Opcode 0x13 selects register-immediate operations and 0x33 register-register operations. Opcodes 0x1b and 0x3b select the immediate and register word forms. In the immediate forms the second operand is the immediate, and funct7 is ignored.
- R2: funct3 0 adds. In register forms (0x33, 0x3b) funct7 0x20 selects subtract and funct7 0 selects add; immediate forms always add.
- R3: funct3 4 gives XOR, 6 gives OR and 7 gives AND of the two 64-bit operands.
- R4: funct3 2 is a signed less-than compare and funct3 3 an unsigned one. The result is exactly 0 or 1. The unsigned immediate compare treats the sign-extended immediate as an unsigned 64-bit value.
- R5: funct3 1 shifts left and funct3 5 shifts right. Full-width shifts use the low 6 bits of rs2 or of the immediate as the amount. A right shift is arithmetic when funct7 is 0x20 (register form) or when the bit-30 input is 1 (immediate form), and logical otherwise.
- R6: Word forms compute on the low 32 bits of the operands, use only the low 5 bits as the shift amount, and sign-extend the 32-bit result to 64 bits. This includes the logical right shift.
- R7: Opcode 0x37 returns the immediate unchanged. Opcode 0x17 returns PC plus the immediate.
- R8: Any other combination raises `illegal`=1 and forces `result` to zero. This includes any other opcode, funct3 2/3/4/6/7 under 0x1b or 0x3b, funct7 values other than 0 and 0x20, and funct7 0x20 with a register-form funct3 other than 0 or 5. Supported encodings give `illegal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 7 | Major opcode of the instruction |
| funct3 | input | 3 | Operation selector |
| funct7 | input | 7 | Variant selector for register forms |
| imm_arith | input | 1 | Instruction bit 30; selects arithmetic right shift for immediate shifts |
| rs1_val | input | 64 | First source register value |
| rs2_val | input | 64 | Second source register value |
| imm_val | input | 64 | Sign-extended immediate |
| pc_val | input | 64 | Program counter of the instruction |
| result | output | 64 | Destination register value |
| illegal | output | 1 | Unsupported encoding; result is zero |

## Verification
The bench targets shift amounts with bits above the legal width set. A design that failed to mask them would shift by 64+n or 32+n and return zero or the wrong bit. Word operations are driven with garbage in the upper operand halves and with results whose bit 31 is set. A missing sign extension would leave zero or stale upper bits, and a logical word right shift done on 64 bits would pull the high half into the result. The unsigned immediate compare against a negative immediate and the funct7 and bit-30 selection of subtract and arithmetic shift are exercised. So are the illegal corners, where a wrong decoder would raise no flag or leak a nonzero result.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam logic [6:0] OPC_IMM   = 7'h13;
    localparam logic [6:0] OPC_REG   = 7'h33;
    localparam logic [6:0] OPC_IMMW  = 7'h1b;
    localparam logic [6:0] OPC_REGW  = 7'h3b;
    localparam logic [6:0] OPC_LUI   = 7'h37;
    localparam logic [6:0] OPC_AUIPC = 7'h17;

    localparam logic [6:0] F7_BASE = 7'h00;
    localparam logic [6:0] F7_ALT  = 7'h20;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU, OP_XOR,
        OP_SRL, OP_SRA, OP_OR, OP_AND, OP_PASS_B, OP_NONE
    } exu_op_e;

    typedef struct packed {
        exu_op_e op;
        logic    use_imm;
        logic    use_pc;
        logic    word;
        logic    illegal;
    } exu_ctrl_t;

    function automatic exu_op_e f3_to_op(input logic [2:0] f3, input logic alt);
        case (f3)
            3'd0:    return alt ? OP_SUB : OP_ADD;
            3'd1:    return OP_SLL;
            3'd2:    return OP_SLT;
            3'd3:    return OP_SLTU;
            3'd4:    return OP_XOR;
            3'd5:    return alt ? OP_SRA : OP_SRL;
            3'd6:    return OP_OR;
            default: return OP_AND;
        endcase
    endfunction

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    input  logic       imm_arith,
    output exu_ctrl_t  ctrl
);

    logic f7_ok;
    logic f3_word_ok;
    logic imm_alt;

    always_comb begin
        // register forms: funct7 must be base, or alt only for add/sub and right shift
        f7_ok      = (funct7 == F7_BASE) ||
                     ((funct7 == F7_ALT) && (funct3 == 3'd0 || funct3 == 3'd5));
        f3_word_ok = (funct3 == 3'd0) || (funct3 == 3'd1) || (funct3 == 3'd5);
        imm_alt    = (funct3 == 3'd5) && imm_arith;

        ctrl = '{op: OP_NONE, use_imm: 1'b0, use_pc: 1'b0, word: 1'b0, illegal: 1'b1};
        case (opcode)
            OPC_IMM: begin
                ctrl.op      = f3_to_op(funct3, imm_alt);
                ctrl.use_imm = 1'b1;
                ctrl.illegal = 1'b0;
            end
            OPC_REG: begin
                if (f7_ok) begin
                    ctrl.op      = f3_to_op(funct3, funct7 == F7_ALT);
                    ctrl.illegal = 1'b0;
                end
            end
            OPC_IMMW: begin
                if (f3_word_ok) begin
                    ctrl.op      = f3_to_op(funct3, imm_alt);
                    ctrl.use_imm = 1'b1;
                    ctrl.word    = 1'b1;
                    ctrl.illegal = 1'b0;
                end
            end
            OPC_REGW: begin
                if (f7_ok && f3_word_ok) begin
                    ctrl.op      = f3_to_op(funct3, funct7 == F7_ALT);
                    ctrl.word    = 1'b1;
                    ctrl.illegal = 1'b0;
                end
            end
            OPC_LUI: begin
                ctrl.op      = OP_PASS_B;
                ctrl.use_imm = 1'b1;
                ctrl.illegal = 1'b0;
            end
            OPC_AUIPC: begin
                ctrl.op      = OP_ADD;
                ctrl.use_imm = 1'b1;
                ctrl.use_pc  = 1'b1;
                ctrl.illegal = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]         src,
    input  logic [$clog2(XLEN)-1:0] shamt,
    input  logic                    word,
    input  logic                    right,
    input  logic                    arith,
    output logic [XLEN-1:0]         y
);

    localparam int HALF = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);

    logic [SHW-1:0]         amt;
    logic signed [XLEN-1:0] rsrc;

    always_comb begin
        // word forms drop the top amount bit
        amt = word ? {1'b0, shamt[SHW-2:0]} : shamt;
        if (word)
            rsrc = arith ? {{HALF{src[HALF-1]}}, src[HALF-1:0]}
                         : {{HALF{1'b0}}, src[HALF-1:0]};
        else
            rsrc = src;
        if (!right)
            y = src << amt;
        else if (arith)
            y = rsrc >>> amt;
        else
            y = rsrc >> amt;
    end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  exu_ctrl_t       ctrl,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] rs2,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] y
);

    localparam int HALF = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);

    logic [XLEN-1:0] opa, opb, shifted, raw;
    logic            lt_s, lt_u;

    assign opa  = ctrl.use_pc ? pc : rs1;
    assign opb  = ctrl.use_imm ? imm : rs2;
    assign lt_s = $signed(opa) < $signed(opb);
    assign lt_u = opa < opb;

    exu_shift #(.XLEN(XLEN)) u_shift (
        .src   (opa),
        .shamt (opb[SHW-1:0]),
        .word  (ctrl.word),
        .right (ctrl.op == OP_SRL || ctrl.op == OP_SRA),
        .arith (ctrl.op == OP_SRA),
        .y     (shifted)
    );

    always_comb begin
        case (ctrl.op)
            OP_ADD:    raw = opa + opb;
            OP_SUB:    raw = opa - opb;
            OP_SLT:    raw = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU:   raw = {{(XLEN-1){1'b0}}, lt_u};
            OP_XOR:    raw = opa ^ opb;
            OP_OR:     raw = opa | opb;
            OP_AND:    raw = opa & opb;
            OP_SLL,
            OP_SRL,
            OP_SRA:    raw = shifted;
            OP_PASS_B: raw = opb;
            default:   raw = '0;
        endcase
        y = ctrl.word ? {{HALF{raw[HALF-1]}}, raw[HALF-1:0]} : raw;
    end

    // R4: compare results carry a single bit
    always_comb begin
        if (ctrl.op == OP_SLT || ctrl.op == OP_SLTU)
            a_r4_cmp_one_bit: assert (y[XLEN-1:1] == '0)
                else $error("compare result wider than one bit");
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exu_pkg::*;
(
    input  logic [6:0]  opcode,
    input  logic [2:0]  funct3,
    input  logic [6:0]  funct7,
    input  logic        imm_arith,
    input  logic [63:0] rs1_val,
    input  logic [63:0] rs2_val,
    input  logic [63:0] imm_val,
    input  logic [63:0] pc_val,
    output logic [63:0] result,
    output logic        illegal
);

    localparam int XLEN = 64;
    localparam int HALF = XLEN / 2;

    exu_ctrl_t       ctrl;
    logic [XLEN-1:0] alu_y;

    exu_decode u_dec (
        .opcode    (opcode),
        .funct3    (funct3),
        .funct7    (funct7),
        .imm_arith (imm_arith),
        .ctrl      (ctrl)
    );

    exu_alu #(.XLEN(XLEN)) u_alu (
        .ctrl (ctrl),
        .rs1  (rs1_val),
        .rs2  (rs2_val),
        .imm  (imm_val),
        .pc   (pc_val),
        .y    (alu_y)
    );

    assign illegal = ctrl.illegal;
    assign result  = ctrl.illegal ? '0 : alu_y;

    always_comb begin
        if (illegal)
            a_r8_illegal_zero: assert (result == '0)
                else $error("illegal encoding leaked a result");
        if (!illegal && (opcode == OPC_IMMW || opcode == OPC_REGW))
            a_r6_word_sext: assert (result[XLEN-1:HALF] == {HALF{result[HALF-1]}})
                else $error("word result not sign-extended");
        if (opcode == OPC_LUI)
            a_r7_lui_pass: assert (result == imm_val && !illegal)
                else $error("upper immediate altered");
        if (opcode == OPC_IMM)
            a_r1_imm_legal: assert (!illegal)
                else $error("register-immediate form flagged illegal");
    end

endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;

    logic        clk = 1'b0;
    logic [6:0]  opcode = '0;
    logic [2:0]  funct3 = '0;
    logic [6:0]  funct7 = '0;
    logic        imm_arith = 1'b0;
    logic [63:0] rs1_val = '0, rs2_val = '0, imm_val = '0, pc_val = '0;
    logic [63:0] result;
    logic        illegal;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    int_exec_unit u0 (
        .opcode    (opcode),
        .funct3    (funct3),
        .funct7    (funct7),
        .imm_arith (imm_arith),
        .rs1_val   (rs1_val),
        .rs2_val   (rs2_val),
        .imm_val   (imm_val),
        .pc_val    (pc_val),
        .result    (result),
        .illegal   (illegal)
    );

    // drive after a rising edge, sample at the falling edge
    task automatic run(input logic [6:0] op, input logic [2:0] f3, input logic [6:0] f7,
                       input logic b30, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] im, input logic [63:0] pc);
        @(posedge clk);
        opcode = op; funct3 = f3; funct7 = f7; imm_arith = b30;
        rs1_val = a; rs2_val = b; imm_val = im; pc_val = pc;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] exp_res, input logic exp_ill);
        n_total++;
        if (result !== exp_res || illegal !== exp_ill) begin
            n_fail++;
            $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                     tag, result, illegal, exp_res, exp_ill);
        end
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        check("R8 idle opcode 0", 64'h0, 1'b1);
    endtask

    task automatic t_add_sub;
        run(7'h33, 3'd0, 7'h00, 0, 64'd5, 64'd7, 0, 0);
        check("R2 add", 64'd12, 0);
        run(7'h33, 3'd0, 7'h20, 0, 64'd5, 64'd7, 0, 0);
        check("R2 sub", 64'hFFFF_FFFF_FFFF_FFFE, 0);
        run(7'h13, 3'd0, 7'h20, 1, 64'd5, 64'd100, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        check("R1 R2 addi ignores funct7 and rs2", 64'd4, 0);
    endtask

    task automatic t_logic;
        run(7'h33, 3'd4, 0, 0, 64'hF0F0, 64'hFF00, 0, 0);
        check("R3 xor", 64'h0FF0, 0);
        run(7'h33, 3'd6, 0, 0, 64'hF0F0, 64'hFF00, 0, 0);
        check("R3 or", 64'hFFF0, 0);
        run(7'h13, 3'd7, 0, 0, 64'hF0F0, 0, 64'hFF00, 0);
        check("R3 andi", 64'hF000, 0);
    endtask

    task automatic t_compare;
        run(7'h33, 3'd2, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0);
        check("R4 slt signed", 64'd1, 0);
        run(7'h33, 3'd3, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0);
        check("R4 sltu", 64'd0, 0);
        run(7'h13, 3'd3, 0, 0, 64'd5, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        check("R4 sltiu negative imm", 64'd1, 0);
        run(7'h13, 3'd2, 0, 0, 64'd5, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        check("R4 slti negative imm", 64'd0, 0);
    endtask

    task automatic t_shift64;
        run(7'h33, 3'd1, 0, 0, 64'd1, 64'd67, 0, 0);
        check("R5 sll masks to 6 bits", 64'd8, 0);
        run(7'h33, 3'd1, 0, 0, 64'd1, 64'd63, 0, 0);
        check("R5 sll by 63", 64'h8000_0000_0000_0000, 0);
        run(7'h33, 3'd5, 0, 0, 64'h8000_0000_0000_0000, 64'd63, 0, 0);
        check("R5 srl", 64'd1, 0);
        run(7'h33, 3'd5, 7'h20, 0, 64'h8000_0000_0000_0000, 64'd63, 0, 0);
        check("R5 sra", 64'hFFFF_FFFF_FFFF_FFFF, 0);
        run(7'h13, 3'd5, 0, 1, 64'hF000_0000_0000_0000, 0, 64'd4, 0);
        check("R5 srai bit30", 64'hFF00_0000_0000_0000, 0);
        run(7'h13, 3'd5, 0, 0, 64'hF000_0000_0000_0000, 0, 64'd4, 0);
        check("R5 srli", 64'h0F00_0000_0000_0000, 0);
    endtask

    task automatic t_word;
        run(7'h3b, 3'd0, 0, 0, 64'h0000_0000_7FFF_FFFF, 64'd1, 0, 0);
        check("R6 addw overflow sext", 64'hFFFF_FFFF_8000_0000, 0);
        run(7'h3b, 3'd0, 7'h20, 0, 64'h1234_0000_0000_0000, 64'd1, 0, 0);
        check("R6 subw", 64'hFFFF_FFFF_FFFF_FFFF, 0);
        run(7'h1b, 3'd0, 0, 0, 64'h0000_0001_0000_0005, 0, 64'd3, 0);
        check("R6 addiw drops high half", 64'd8, 0);
        run(7'h3b, 3'd1, 0, 0, 64'd1, 64'd63, 0, 0);
        check("R6 sllw masks to 5 bits", 64'hFFFF_FFFF_8000_0000, 0);
        run(7'h3b, 3'd5, 0, 0, 64'hFFFF_FFFF_8000_0000, 64'd0, 0, 0);
        check("R6 srlw by 0 sext", 64'hFFFF_FFFF_8000_0000, 0);
        run(7'h3b, 3'd5, 0, 0, 64'hFFFF_FFFF_8000_0000, 64'd33, 0, 0);
        check("R6 srlw by 1", 64'h0000_0000_4000_0000, 0);
        run(7'h3b, 3'd5, 7'h20, 0, 64'h0000_0000_8000_0000, 64'd4, 0, 0);
        check("R6 sraw", 64'hFFFF_FFFF_F800_0000, 0);
        run(7'h1b, 3'd5, 0, 1, 64'h0000_0000_8000_0000, 0, 64'd4, 0);
        check("R6 sraiw bit30", 64'hFFFF_FFFF_F800_0000, 0);
        run(7'h1b, 3'd5, 0, 0, 64'hABCD_0000_0000_0010, 0, 64'd4, 0);
        check("R6 srliw ignores high half", 64'd1, 0);
    endtask

    task automatic t_upper;
        run(7'h37, 3'd5, 7'h7F, 1, 64'd9, 64'd9, 64'hFFFF_FFFF_1234_5000, 64'h40);
        check("R7 lui", 64'hFFFF_FFFF_1234_5000, 0);
        run(7'h17, 3'd0, 0, 0, 64'd9, 64'd9, 64'h2000, 64'h1000);
        check("R7 auipc", 64'h3000, 0);
    endtask

    task automatic t_illegal;
        run(7'h1b, 3'd2, 0, 0, 64'd5, 64'd5, 64'd5, 0);
        check("R8 word funct3 2", 64'h0, 1);
        run(7'h33, 3'd0, 7'h01, 0, 64'd5, 64'd5, 0, 0);
        check("R8 funct7 0x01", 64'h0, 1);
        run(7'h33, 3'd1, 7'h20, 0, 64'd5, 64'd5, 0, 0);
        check("R8 alt funct7 on sll", 64'h0, 1);
        run(7'h3b, 3'd4, 0, 0, 64'd5, 64'd5, 0, 0);
        check("R8 word xor", 64'h0, 1);
        run(7'h03, 3'd0, 0, 0, 64'd5, 64'd5, 64'd5, 0);
        check("R8 other opcode", 64'h0, 1);
    endtask

    initial begin
        t_reset_state();
        t_add_sub();
        t_logic();
        t_compare();
        t_shift64();
        t_word();
        t_upper();
        t_illegal();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule